// File: doc/BRIEF.md
# Byte-Enabled Synchronous Memory Port

This block is one clocked access port onto an on-chip memory that is eighteen bits wide and split into two nine-bit byte lanes. On each rising clock edge it captures a pair of chip selects (one active low, one active high), an active-low enable for each byte lane, a read/write control, an address and write data. A captured write updates only the lanes whose enable is low. A captured read returns the addressed word either one cycle after capture (flow-through) or two cycles after capture (pipelined), as chosen by a mode input.

There are no physical tri-state pins. Each byte lane has a valid flag that shows whether the lane would be driving. The lane select that was captured with a read address moves down the same pipeline as the returned word, so the mask always lines up with the data it belongs to. The output enable is the one control that acts at once, without waiting for a clock edge. A lane that is not driving shows zero on its data bits.

Top module: `smp_port`

## Requirements
- R1: The port is selected only when `cs_n_i` is 0 and `cs_i` is 1. An access captured while deselected writes nothing, and in flow-through mode it leaves both `dout_vld_o` bits at 0 in the following cycle.
- R2: Lane enable `be_hi_n_i` (active low) governs data bits 17..9, shown by `dout_vld_o[1]`. Lane enable `be_lo_n_i` (active low) governs bits 8..0, shown by `dout_vld_o[0]`. Any combination of the two is accepted on an access.
- R3: A selected access with `rw_n_i` = 0 writes, and only the lanes with enable 0 are updated. No lane is flagged valid for the cycle that belongs to a write.
- R4: A selected read flags valid and drives only its enabled lanes. A lane that is not valid reads as zero on `dout_o`.
- R5: While `oe_n_i` is 1, both valid flags are 0 and `dout_o` is zero. This takes effect within the same cycle, with no clock edge needed.
- R6: With `pipe_mode_i` = 0, read data is valid in the cycle after the edge that samples the address. With `pipe_mode_i` = 1, it is valid one cycle later than that.
- R7: The lane enables and chip selects captured with a read travel with its data. Controls presented on later cycles do not change the mask of a word already in flight.
- R8: A write followed on the next cycle by a read of the same address returns the newly written lanes.
- R9: While `rst_n` is 0, and after reset until a read is captured, both valid flags are 0.
- R10: Deselecting through the chip selects or lane enables takes effect only after the next rising edge. An output already valid stays valid until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode_i | input | 1 | 0 = flow-through reads, 1 = pipelined reads |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| cs_n_i | input | 1 | Active-low chip select |
| cs_i | input | 1 | Active-high chip select |
| be_hi_n_i | input | 1 | Active-low enable for bits 17..9 |
| be_lo_n_i | input | 1 | Active-low enable for bits 8..0 |
| rw_n_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 2*BYTE_W | Write data |
| dout_o | output | 2*BYTE_W | Read data, zero on lanes that are not valid |
| dout_vld_o | output | 2 | Per-lane driving flag, bit 1 upper, bit 0 lower |

## Verification
Each access is driven on a falling edge and captured on the next rising edge. The bench then samples one time unit after that rising edge for flow-through results, and one time unit after the following rising edge for pipelined results, so that every sample falls in a settled part of the cycle. A write reaches the array on the edge after its capture, so read-backs are issued no earlier than the next cycle. That is exactly the R8 case. The output-enable checks and the mid-cycle deselect checks change an input between edges and sample one time unit later. This separates the asynchronous path (R5) from the clocked ones (R10).

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int NB = 2;

  function automatic logic f_selected(input logic cs_n, input logic cs);
    return (!cs_n) && cs;
  endfunction

  function automatic logic [NB-1:0] f_lanes(input logic hi_n, input logic lo_n);
    return {!hi_n, !lo_n};
  endfunction

  function automatic logic [NB-1:0] f_gate(input logic [NB-1:0] lanes, input logic oe_n);
    return oe_n ? '0 : lanes;
  endfunction
endpackage

// File: rtl/smp_in_stage.sv
module smp_in_stage #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n_i,
  input  logic                          cs_i,
  input  logic                          be_hi_n_i,
  input  logic                          be_lo_n_i,
  input  logic                          rw_n_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [smp_pkg::NB*BYTE_W-1:0] wdata_i,
  output logic [smp_pkg::NB-1:0]        wr_lane_o,
  output logic [smp_pkg::NB-1:0]        rd_lane_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [smp_pkg::NB*BYTE_W-1:0] wdata_o
);
  import smp_pkg::*;

  logic cs_n_q, cs_q, hi_n_q, lo_n_q, rw_n_q;
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      cs_q   <= 1'b0;
      hi_n_q <= 1'b1;
      lo_n_q <= 1'b1;
      rw_n_q <= 1'b1;
    end else begin
      cs_n_q <= cs_n_i;
      cs_q   <= cs_i;
      hi_n_q <= be_hi_n_i;
      lo_n_q <= be_lo_n_i;
      rw_n_q <= rw_n_i;
    end
  end

  always_ff @(posedge clk) begin
    addr_o  <= addr_i;
    wdata_o <= wdata_i;
  end

  assign sel_q     = f_selected(cs_n_q, cs_q);
  assign wr_lane_o = (sel_q && !rw_n_q) ? f_lanes(hi_n_q, lo_n_q) : '0;
  assign rd_lane_o = (sel_q &&  rw_n_q) ? f_lanes(hi_n_q, lo_n_q) : '0;
endmodule

// File: rtl/smp_array.sv
module smp_array #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9
) (
  input  logic                          clk,
  input  logic [smp_pkg::NB-1:0]        wr_lane_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [smp_pkg::NB*BYTE_W-1:0] wdata_i,
  output logic [smp_pkg::NB*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < smp_pkg::NB; b++) begin : g_lane
    logic [BYTE_W-1:0] mem_lane [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lane_i[b]) mem_lane[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
    assign rdata_o[b*BYTE_W +: BYTE_W] = mem_lane[addr_i];
  end
endmodule

// File: rtl/smp_out_stage.sv
module smp_out_stage #(
  parameter int BYTE_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pipe_mode_i,
  input  logic                          oe_n_i,
  input  logic [smp_pkg::NB-1:0]        rd_lane_i,
  input  logic [smp_pkg::NB*BYTE_W-1:0] rdata_i,
  output logic [smp_pkg::NB*BYTE_W-1:0] dout_o,
  output logic [smp_pkg::NB-1:0]        vld_o
);
  import smp_pkg::*;

  logic [NB-1:0]        lane_q2;
  logic [NB*BYTE_W-1:0] data_q2;
  logic [NB-1:0]        lane_sel;
  logic [NB*BYTE_W-1:0] data_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q2 <= '0;
    else        lane_q2 <= rd_lane_i;
  end

  always_ff @(posedge clk) data_q2 <= rdata_i;

  assign lane_sel = pipe_mode_i ? lane_q2 : rd_lane_i;
  assign data_sel = pipe_mode_i ? data_q2 : rdata_i;
  assign vld_o    = f_gate(lane_sel, oe_n_i);

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign dout_o[b*BYTE_W +: BYTE_W] = vld_o[b] ? data_sel[b*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/smp_port.sv
module smp_port #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pipe_mode_i,
  input  logic                  oe_n_i,
  input  logic                  cs_n_i,
  input  logic                  cs_i,
  input  logic                  be_hi_n_i,
  input  logic                  be_lo_n_i,
  input  logic                  rw_n_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*BYTE_W-1:0]   wdata_i,
  output logic [2*BYTE_W-1:0]   dout_o,
  output logic [1:0]            dout_vld_o
);
  localparam int DW = smp_pkg::NB * BYTE_W;

  logic [smp_pkg::NB-1:0] wr_lane_s1;
  logic [smp_pkg::NB-1:0] rd_lane_s1;
  logic [ADDR_W-1:0]      addr_s1;
  logic [DW-1:0]          wdata_s1;
  logic [DW-1:0]          rdata_s1;

  smp_in_stage #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .cs_i(cs_i),
    .be_hi_n_i(be_hi_n_i), .be_lo_n_i(be_lo_n_i), .rw_n_i(rw_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_lane_o(wr_lane_s1), .rd_lane_o(rd_lane_s1),
    .addr_o(addr_s1), .wdata_o(wdata_s1)
  );

  smp_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .wr_lane_i(wr_lane_s1), .addr_i(addr_s1),
    .wdata_i(wdata_s1), .rdata_o(rdata_s1)
  );

  smp_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode_i(pipe_mode_i), .oe_n_i(oe_n_i),
    .rd_lane_i(rd_lane_s1), .rdata_i(rdata_s1),
    .dout_o(dout_o), .vld_o(dout_vld_o)
  );

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode_i && ($past(cs_n_i) || !$past(cs_i))) |-> (dout_vld_o == 2'b00)); // R1
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode_i && !$past(rw_n_i)) |-> (dout_vld_o == 2'b00)); // R3
  AST_HI_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode_i && $past(be_hi_n_i)) |-> !dout_vld_o[1]); // R4
  AST_PIPE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode_i && $past(pipe_mode_i) && $past(cs_n_i, 2)) |-> (dout_vld_o == 2'b00)); // R6
  AST_NO_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_lane_s1) > 0 |-> rd_lane_s1 == '0); // R3
endmodule

// File: tb/test_smp_port.sv
module test_smp_port;
  localparam int AW = 8;
  localparam int BW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b0, oe_n = 1'b0;
  logic cs_n = 1'b1, cs = 1'b0, hi_n = 1'b1, lo_n = 1'b1, rw_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [2*BW-1:0] wdata = '0;
  logic [2*BW-1:0] dout;
  logic [1:0] vld;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  smp_port #(.ADDR_W(AW), .BYTE_W(BW)) i_smp_port (
    .clk(clk), .rst_n(rst_n), .pipe_mode_i(pipe_mode), .oe_n_i(oe_n),
    .cs_n_i(cs_n), .cs_i(cs), .be_hi_n_i(hi_n), .be_lo_n_i(lo_n),
    .rw_n_i(rw_n), .addr_i(addr), .wdata_i(wdata),
    .dout_o(dout), .dout_vld_o(vld)
  );

  function automatic logic [2*BW-1:0] mk(input logic [BW-1:0] h, input logic [BW-1:0] l);
    return {h, l};
  endfunction

  task automatic chk(input string req, input logic [1:0] ev, input logic [2*BW-1:0] ed);
    n_chk++;
    if (vld !== ev || dout !== ed) begin
      n_fail++;
      $display("FAIL %s: vld=%b dout=%h expected vld=%b dout=%h", req, vld, dout, ev, ed);
    end
  endtask

  task automatic drive(input logic c_n, input logic c, input logic h_n, input logic l_n,
                       input logic r_n, input logic [AW-1:0] a, input logic [2*BW-1:0] d);
    @(negedge clk);
    cs_n = c_n; cs = c; hi_n = h_n; lo_n = l_n; rw_n = r_n; addr = a; wdata = d;
  endtask

  task automatic idle();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic wr(input logic h_n, input logic l_n, input logic [AW-1:0] a, input logic [2*BW-1:0] d);
    drive(1'b0, 1'b1, h_n, l_n, 1'b0, a, d);
    @(posedge clk); #1;
  endtask

  task automatic rd_flow(input logic h_n, input logic l_n, input logic [AW-1:0] a);
    drive(1'b0, 1'b1, h_n, l_n, 1'b1, a, '0);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1 chk("R9 during reset", 2'b00, '0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk("R9 after reset", 2'b00, '0);
  endtask

  task automatic t_write_read();
    wr(1'b0, 1'b0, 8'h10, mk(9'h1A5, 9'h05A));
    chk("R3 no output on write", 2'b00, '0);
    idle(); @(posedge clk);
    rd_flow(1'b0, 1'b0, 8'h10);
    chk("R6 flow latency", 2'b11, mk(9'h1A5, 9'h05A));
    wr(1'b0, 1'b1, 8'h10, mk(9'h0C3, 9'h111));
    idle(); @(posedge clk);
    rd_flow(1'b0, 1'b0, 8'h10);
    chk("R3 upper-only write", 2'b11, mk(9'h0C3, 9'h05A));
    wr(1'b1, 1'b0, 8'h10, mk(9'h1FF, 9'h0F0));
    idle(); @(posedge clk);
    rd_flow(1'b0, 1'b0, 8'h10);
    chk("R2 lower-only write", 2'b11, mk(9'h0C3, 9'h0F0));
  endtask

  task automatic t_byte_read();
    rd_flow(1'b0, 1'b1, 8'h10);
    chk("R4 upper lane only", 2'b10, mk(9'h0C3, 9'h000));
    rd_flow(1'b1, 1'b0, 8'h10);
    chk("R4 lower lane only", 2'b01, mk(9'h000, 9'h0F0));
    rd_flow(1'b1, 1'b1, 8'h10);
    chk("R2 no lanes", 2'b00, '0);
  endtask

  task automatic t_deselect();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h10, mk(9'h0AA, 9'h0AA));
    @(posedge clk); #1 chk("R1 cs_n high", 2'b00, '0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, mk(9'h0BB, 9'h0BB));
    @(posedge clk); #1 chk("R1 cs low", 2'b00, '0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h10, '0);
    @(posedge clk); #1 chk("R1 deselected read", 2'b00, '0);
    rd_flow(1'b0, 1'b0, 8'h10);
    chk("R1 contents kept", 2'b11, mk(9'h0C3, 9'h0F0));
  endtask

  task automatic t_oe();
    rd_flow(1'b0, 1'b0, 8'h10);
    oe_n = 1'b1; #1 chk("R5 oe high", 2'b00, '0);
    oe_n = 1'b0; #1 chk("R5 oe restored", 2'b11, mk(9'h0C3, 9'h0F0));
  endtask

  task automatic t_desel_timing();
    rd_flow(1'b0, 1'b0, 8'h10);
    cs_n = 1'b1; #1 chk("R10 cs_n mid-cycle", 2'b11, mk(9'h0C3, 9'h0F0));
    cs_n = 1'b0; hi_n = 1'b1; #1 chk("R10 be mid-cycle", 2'b11, mk(9'h0C3, 9'h0F0));
    @(posedge clk); #1 chk("R10 after edge", 2'b01, mk(9'h000, 9'h0F0));
  endtask

  task automatic t_forward();
    wr(1'b0, 1'b0, 8'h22, mk(9'h13C, 9'h0E7));
    rd_flow(1'b0, 1'b0, 8'h22);
    chk("R8 back-to-back", 2'b11, mk(9'h13C, 9'h0E7));
  endtask

  task automatic t_pipe();
    idle(); pipe_mode = 1'b1;
    @(posedge clk); @(posedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h22, '0);
    @(posedge clk); #1 chk("R6 pipe not yet", 2'b00, '0);
    idle();
    @(posedge clk); #1 chk("R6 pipe data", 2'b11, mk(9'h13C, 9'h0E7));
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h10, '0);
    @(posedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h22, '0);
    @(posedge clk); #1 chk("R7 mask travels", 2'b01, mk(9'h000, 9'h0F0));
    idle();
    @(posedge clk); #1 chk("R7 second word", 2'b10, mk(9'h13C, 9'h000));
    wr(1'b0, 1'b0, 8'h33, mk(9'h055, 9'h0AA));
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33, '0);
    @(posedge clk); idle();
    @(posedge clk); #1 chk("R8 pipe back-to-back", 2'b11, mk(9'h055, 9'h0AA));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_write_read();
        t_byte_read();
        t_deselect();
        t_oe();
        t_desel_timing();
        t_forward();
        t_pipe();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule